// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes four level-sensitive PCI interrupt lines and drives sixteen ISA interrupt request lines. Each PCI line has a byte-wide steering register. A value from 0 to 15 selects the ISA request the line drives. Any larger value detaches the line. Several PCI lines may point at the same ISA request, and that request then reflects the OR of their levels.

The steering bytes sit in one 32-bit dword of a byte-addressed configuration window. Host software writes them with byte enables and reads them back. The block keeps a 16 by 4 bit level map with one bit per (ISA request, PCI line) pair. A small state machine maintains this map.

- In the RUN state, each cycle refreshes only the bit at every line's current target.
- A write that touches any steering byte moves the machine to REBUILD. In the next cycle it clears the map and refills it from the present line levels. It stays in REBUILD while further steering writes arrive and returns to RUN after the first cycle without one.
- The route-change output is high exactly while the machine is in REBUILD.
- Per-line outputs report whether each line is attached and which request it drives.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, every steering byte reads 0x80, every line reports detached with target 0, all sixteen ISA outputs are low and the route-change output is low.
- R2: The steering dword is at byte address 0x60 (cfg_addr[7:2] = 0x18; cfg_addr[1:0] are ignored). Byte lane k (cfg_wdata[8k+7:8k], cfg_be[k]) holds the byte for line k (lane 0 is line A, lane 3 is line D). A write updates exactly the enabled lanes. Reading at that dword returns the four stored bytes exactly as written, in the same lanes, with no register stage.
- R3: A write to any other dword, or a write with all byte enables low, changes no steering byte and does not raise the route-change output. Reads of any other dword return 0.
- R4: A steering value of 16 or more detaches the line. It reports detached (route_en_o bit 0) with target field 0 and drives no ISA output. A value of exactly 16 is detached; 15 is attached.
- R5: A steering value below 16 reports the line attached (route_en_o bit 1), with the value in that line's 4-bit field of route_irq_o (line k at bits 4k+3:4k).
- R6: Once the routing is settled, ISA output i is high exactly when at least one attached line with target i is high. Lines that share a target combine by OR.
- R7: When the steering is unchanged, a change on a PCI input appears on the ISA outputs after the next rising clock edge.
- R8: The route-change output is high in the cycle after each clock edge that accepts a steering write. The ISA outputs match the new steering and the present line levels after the second edge counted from the accepting edge.
- R9: When a line moves from one target to another, the old target no longer shows that line's level after the rebuild.
- R10: Back-to-back steering writes keep the machine in REBUILD, so the route-change output stays high for one cycle per accepting edge. The machine returns to RUN after the first edge without such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword select in bits 7:2) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed dword |
| pci_int_i | input | 4 | PCI interrupt levels, bit 0 is line A |
| isa_irq_o | output | 16 | ISA interrupt request levels |
| route_chg_o | output | 1 | High while the level map is being rebuilt after a steering write |
| route_en_o | output | 4 | Per-line attached flag |
| route_irq_o | output | 16 | Per-line 4-bit target, 0 when detached |

## Verification
The assertions assume that reset holds the configuration strobe low and that routing is judged only in the RUN state. Between a steering write and the rebuild, the map may still hold the previous routing. The bench follows these rules: it drives every input at the falling edge and holds the PCI levels still across each write. It compares the ISA outputs only after the rebuild edge, or one edge after a level change. Its random steering bytes are split between values below 16 and values across the full byte range, so both attached and detached lines appear often.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    typedef logic [7:0] route_byte_t;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_REBUILD = 1'b1
    } map_state_e;
endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 4,
    parameter logic [7:0]  ROUTE_BASE  = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [7:0]                          addr,
    input  logic [3:0]                          be,
    input  logic [31:0]                         wdata,
    output logic [31:0]                         rdata,
    output logic [NUM_PINS-1:0][7:0]            routes_o,
    output logic                                hit_o
);
    localparam logic [5:0] BASE_DW = ROUTE_BASE[7:2];

    logic                 addr_hit;
    logic [NUM_PINS-1:0]  byte_we;
    route_byte_t          route_q [NUM_PINS];
    logic                 unused_addr_bits;

    assign unused_addr_bits = ^addr[1:0];
    assign addr_hit         = (addr[7:2] == BASE_DW);
    assign hit_o            = |byte_we;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_lane
        assign byte_we[k]  = wr_en & addr_hit & be[k];
        assign routes_o[k] = route_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          route_q[k] <= RESET_ROUTE;
            else if (byte_we[k]) route_q[k] <= wdata[8*k +: 8];
        end

        AST_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_we[k]) |=> (route_q[k] == $past(wdata[8*k +: 8]))); // R2
    end

    always_comb begin
        rdata = '0;
        if (addr_hit) begin
            for (int k = 0; k < NUM_PINS; k++) rdata[8*k +: 8] = route_q[k];
        end
    end

    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_o) |=> $stable(routes_o)); // R3
endmodule

// File: rtl/route_report.sv
module route_report #(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned NUM_IRQS = 16,
    parameter int unsigned IRQ_W    = 4
) (
    input  logic [NUM_PINS-1:0][7:0]        routes_i,
    output logic [NUM_PINS-1:0]             en_o,
    output logic [NUM_PINS-1:0][IRQ_W-1:0]  tgt_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign en_o[p]  = (32'(routes_i[p]) < NUM_IRQS);
        assign tgt_o[p] = en_o[p] ? routes_i[p][IRQ_W-1:0] : '0;
    end
endmodule

// File: rtl/irq_map_engine.sv
module irq_map_engine
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned NUM_IRQS = 16,
    parameter int unsigned IRQ_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rebuild_req_i,
    input  logic [NUM_PINS-1:0]             pci_i,
    input  logic [NUM_PINS-1:0]             en_i,
    input  logic [NUM_PINS-1:0][IRQ_W-1:0]  tgt_i,
    output logic [NUM_IRQS-1:0]             irq_o,
    output logic                            chg_o
);
    map_state_e                          state_q, state_d;
    logic [NUM_IRQS-1:0][NUM_PINS-1:0]   map_q, map_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (rebuild_req_i) state_d = ST_REBUILD;
            ST_REBUILD: if (!rebuild_req_i) state_d = ST_RUN;
        endcase
    end

    // level map update: one bit per line in RUN, full refill in REBUILD
    always_comb begin
        map_d = map_q;
        unique case (state_q)
            ST_RUN: begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (en_i[p]) map_d[tgt_i[p]][p] = pci_i[p];
            end
            ST_REBUILD: begin
                map_d = '0;
                for (int p = 0; p < NUM_PINS; p++)
                    if (en_i[p]) map_d[tgt_i[p]][p] = pci_i[p];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            map_q   <= '0;
        end else begin
            state_q <= state_d;
            map_q   <= map_d;
        end
    end

    // outputs
    always_comb begin
        chg_o = (state_q == ST_REBUILD);
        for (int i = 0; i < NUM_IRQS; i++) irq_o[i] = |map_q[i];
    end

    // checker-side views
    logic [NUM_IRQS-1:0]               reach;
    logic [NUM_PINS-1:0][NUM_IRQS-1:0] col;
    always_comb begin
        reach = '0;
        for (int p = 0; p < NUM_PINS; p++)
            if (en_i[p]) reach[tgt_i[p]] = 1'b1;
        for (int p = 0; p < NUM_PINS; p++)
            for (int i = 0; i < NUM_IRQS; i++) col[p][i] = map_q[i][p];
    end

    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_irq_chk
        AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_RUN && irq_o[i]) |-> reach[i]); // R6
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
        AST_DETACHED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_RUN && !en_i[p]) |-> (col[p] == '0)); // R4
        AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[p])); // R9
    end

    AST_CHG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rebuild_req_i |=> chg_o); // R8
    AST_BACK_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !rebuild_req_i |=> (state_q == ST_RUN)); // R10
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 4,
    parameter int unsigned NUM_IRQS    = 16,
    parameter logic [7:0]  ROUTE_BASE  = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80,
    localparam int unsigned IRQ_W      = $clog2(NUM_IRQS),
    localparam int unsigned TGT_W      = NUM_PINS * IRQ_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [7:0]           cfg_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [NUM_PINS-1:0]  pci_int_i,
    output logic [NUM_IRQS-1:0]  isa_irq_o,
    output logic                 route_chg_o,
    output logic [NUM_PINS-1:0]  route_en_o,
    output logic [TGT_W-1:0]     route_irq_o
);
    logic [NUM_PINS-1:0][7:0]       routes;
    logic [NUM_PINS-1:0][IRQ_W-1:0] tgt;
    logic                           wr_hit;

    route_cfg_regs #(
        .NUM_PINS(NUM_PINS), .ROUTE_BASE(ROUTE_BASE), .RESET_ROUTE(RESET_ROUTE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .be(cfg_be), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .routes_o(routes), .hit_o(wr_hit)
    );

    route_report #(
        .NUM_PINS(NUM_PINS), .NUM_IRQS(NUM_IRQS), .IRQ_W(IRQ_W)
    ) u_report (
        .routes_i(routes), .en_o(route_en_o), .tgt_o(tgt)
    );

    irq_map_engine #(
        .NUM_PINS(NUM_PINS), .NUM_IRQS(NUM_IRQS), .IRQ_W(IRQ_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .rebuild_req_i(wr_hit), .pci_i(pci_int_i),
        .en_i(route_en_o), .tgt_i(tgt), .irq_o(isa_irq_o), .chg_o(route_chg_o)
    );

    assign route_irq_o = tgt;
endmodule

// File: tb/pci_irq_router_tb_top.sv
`timescale 1ns/1ps
module pci_irq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h60;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pci_int_i = 4'h0;
    logic [15:0] isa_irq_o;
    logic        route_chg_o;
    logic [3:0]  route_en_o;
    logic [15:0] route_irq_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    logic [7:0] m_route [4];

    always #2.5 clk = ~clk;

    pci_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pci_int_i(pci_int_i), .isa_irq_o(isa_irq_o), .route_chg_o(route_chg_o),
        .route_en_o(route_en_o), .route_irq_o(route_irq_o)
    );

    function automatic logic [15:0] exp_irq(logic [3:0] lv);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (m_route[p] < 8'd16 && lv[p]) r[m_route[p][3:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [3:0] exp_en();
        logic [3:0] r;
        for (int p = 0; p < 4; p++) r[p] = (m_route[p] < 8'd16);
        return r;
    endfunction

    function automatic logic [15:0] exp_tgt();
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (m_route[p] < 8'd16) r[4*p +: 4] = m_route[p][3:0];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(string req);
        cfg_addr = 8'h60;
        #0.1;
        check({req, " rdata"}, cfg_rdata, {m_route[3], m_route[2], m_route[1], m_route[0]});
        check({req, " en"}, {28'b0, route_en_o}, {28'b0, exp_en()});
        check({req, " tgt"}, {16'b0, route_irq_o}, {16'b0, exp_tgt()});
        check({req, " irq"}, {16'b0, isa_irq_o}, {16'b0, exp_irq(pci_int_i)});
    endtask

    // single write; PCI levels held; checks the notify pulse around it
    task automatic cfg_write(logic [7:0] a, logic [3:0] b, logic [31:0] d, string req);
        bit hit;
        hit = (a[7:2] == 6'h18) && (b != 4'h0);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
        tick();
        cfg_wr_en = 1'b0; cfg_be = 4'h0;
        if (a[7:2] == 6'h18)
            for (int k = 0; k < 4; k++) if (b[k]) m_route[k] = d[8*k +: 8];
        check({req, " R8 chg after write"}, {31'b0, route_chg_o}, {31'b0, hit});
        tick();
        check({req, " R10 chg drops"}, {31'b0, route_chg_o}, 32'd0);
    endtask

    task automatic set_pins(logic [3:0] v, string req);
        pci_int_i = v;
        tick();
        check({req, " R7 irq after edge"}, {16'b0, isa_irq_o}, {16'b0, exp_irq(pci_int_i)});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        for (int k = 0; k < 4; k++) m_route[k] = 8'h80;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check_state("R1");
        check("R1 chg", {31'b0, route_chg_o}, 32'd0);

        // R5 / R6 shared target, R2 partial byte enables
        cfg_write(8'h60, 4'b0011, 32'h0000_0505, "R2");
        check_state("R5");
        set_pins(4'b0011, "R6 shared");
        set_pins(4'b0010, "R6 one of shared");
        check("R6 irq5 held", {31'b0, isa_irq_o[5]}, 32'd1);

        // R9 move line B from 5 to 9 while high
        cfg_write(8'h61, 4'b0010, 32'h0000_0900, "R9");
        check_state("R9");
        check("R9 old target low", {31'b0, isa_irq_o[5]}, 32'd0);

        // R4 boundary 16 vs 15
        set_pins(4'b1111, "R4 pins");
        cfg_write(8'h62, 4'b1100, 32'h1010_0000, "R4 16");
        check_state("R4 value 16");
        cfg_write(8'h60, 4'b1100, 32'h0f0f_0000, "R4 15");
        check_state("R5 value 15");
        cfg_write(8'h60, 4'b1111, 32'hff_80_11_03, "R4 ff");
        check_state("R4 ff");

        // R3 misses
        cfg_write(8'h64, 4'b1111, 32'h0102_0304, "R3 other dword");
        check_state("R3 other dword");
        cfg_addr = 8'h64; #0.1;
        check("R3 read other", cfg_rdata, 32'd0);
        cfg_write(8'h60, 4'b0000, 32'h0102_0304, "R3 be zero");
        check_state("R3 be zero");

        // R10 back-to-back writes
        cfg_wr_en = 1'b1; cfg_addr = 8'h60; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0007;
        tick();
        m_route[0] = 8'h07;
        check("R10 chg first", {31'b0, route_chg_o}, 32'd1);
        cfg_be = 4'b0010; cfg_wdata = 32'h0000_0700;
        tick();
        m_route[1] = 8'h07;
        cfg_wr_en = 1'b0; cfg_be = 4'h0;
        check("R10 chg second", {31'b0, route_chg_o}, 32'd1);
        tick();
        check("R10 chg off", {31'b0, route_chg_o}, 32'd0);
        check_state("R10 settled");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom % 4;
            if (op < 2) begin
                set_pins(4'($urandom), "R7 random");
            end else begin
                logic [31:0] d;
                logic [7:0]  a;
                for (int k = 0; k < 4; k++)
                    d[8*k +: 8] = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
                a = ($urandom % 5 == 0) ? 8'($urandom) : {6'h18, 2'($urandom)};
                cfg_write(a, 4'($urandom), d, "R8 random");
                check_state("R6 random");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule